// File: doc/BRIEF.md
# Bus Error Check and Report Controller

This block sits beside the system-bus interface of a processor agent and watches the bus for parity faults. It checks one parity line over the request phase, which covers the address lines, the address strobe and the request-type lines. It checks a second parity line over the 3-bit response code. It also accepts a data-path error indication from the data-bus logic. Each fault class can raise a sticky status flag and can pulse one of two active-low error outputs: an address-error drive and a bus-error drive. Each fault class has its own enable in a small policy register that software programs.

All software-writable policy enables come out of reset cleared. The enable for the address-error input receiver is not written by software. It is taken from address line 8 as reset is released, and it cannot be overridden later. The policy register has a bit for reporting errors that a target agent detects. That bit can be written and read back, but this agent never raises the bus-error output for target-detected errors.

Top module: `bus_err_ctrl`

## Requirements
- R1: After reset, policy bits 4..0 read 0, all status bits read 0, and `aerr_out_n` and `berr_out_n` are both 1.
- R2: Request parity is always checked. On a cycle with `bus_ads_n` = 0, the XOR of `bus_addr_n`, `bus_ads_n`, `bus_req_n` and `bus_ap_n` must be 0 (even parity over line levels). If it is 1, status bit 0 is set; it becomes readable two clock edges after the sampled cycle.
- R3: Policy bit 2 enables address-error drive. When it is 1, a request parity fault drives `aerr_out_n` low for exactly the one cycle that follows the sampled cycle. When it is 0, `aerr_out_n` stays 1.
- R4: Policy bit 1 enables the response check. A response is sampled whenever `bus_rs_n` differs from 3'b111. The response fails when the XOR of `bus_rs_n` and `bus_rsp_n` is 1, and a failure sets status bit 1 only if bit 1 is 1.
- R5: Policy bit 0 enables the data check. `data_err_in` = 1 sets status bit 2 when bit 0 is 1. When bit 0 is 0, the input has no effect on the status or on `berr_out_n`.
- R6: Policy bit 3 enables initiator bus-error drive. When it is 1, a flagged response or data fault drives `berr_out_n` low for the one cycle that follows the sampled cycle. When it is 0, `berr_out_n` stays 1.
- R7: Policy bit 4 (target bus-error drive) can be written and read back. It never causes `berr_out_n` to go low.
- R8: Policy bit 5 is read-only. It holds the inverse of `bus_addr_n[8]` as sampled on the last clock edge with `rst_n` = 0. Software writes do not change it.
- R9: When policy bit 5 is 1, `aerr_in_n` = 0 sets status bit 3 two edges later. When bit 5 is 0, the input is ignored and status bit 3 stays 0.
- R10: A write to address 1 clears each status bit whose data bit is 1 and leaves the others unchanged. A new fault that arrives at the same edge as its clear wins, and the bit stays 1.
- R11: `cfg_addr` = 0 selects the policy register and 1 selects the status register. `cfg_rdata` follows combinationally, and unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 = policy, 1 = status |
| cfg_wdata | input | CFG_DW | Write data |
| cfg_rdata | output | CFG_DW | Read data of the selected register |
| bus_addr_n | input | ADDR_W | Request address lines 35..3, active-low |
| bus_ads_n | input | 1 | Address strobe, active-low |
| bus_req_n | input | REQ_W | Request-type lines, active-low |
| bus_ap_n | input | 1 | Request parity line |
| bus_rs_n | input | RS_W | Response code, active-low; 3'b111 means idle |
| bus_rsp_n | input | 1 | Response parity line |
| data_err_in | input | 1 | Data-bus error indication, active-high |
| aerr_in_n | input | 1 | External address-error input, active-low |
| aerr_out_n | output | 1 | Address-error drive, active-low pulse |
| berr_out_n | output | 1 | Bus-error drive, active-low pulse |
| sts_o | output | 4 | Sticky status: 0 request, 1 response, 2 data, 3 external address error |

## Verification
A software clear of a status bit can land at the same clock edge as a new fault that sets that bit. The bench provokes this collision on the data-error flag. It pulses `data_err_in` one cycle and then issues the clearing write to the status register in the next cycle, so that the write and the registered set reach the same edge. It judges the result by reading the bit back as still 1. A later write on its own must then clear the bit, which confirms that the clear path itself works.

// File: rtl/bec_pkg.sv
package bec_pkg;
   localparam int POL_W = 6;
   localparam int STS_W = 4;

   // status bit positions
   localparam int ST_REQ = 0;
   localparam int ST_RSP = 1;
   localparam int ST_DAT = 2;
   localparam int ST_EXT = 3;

   // policy register, packed MSB first: obs_en is bit 5, dat_chk bit 0
   typedef struct packed {
      logic obs_en;
      logic tgt_drv;
      logic init_drv;
      logic aerr_drv;
      logic rsp_chk;
      logic dat_chk;
   } pol_t;
endpackage

// File: rtl/bec_par_chk.sv
module bec_par_chk #(
   parameter int W       = 2,
   parameter bit ODD_PAR = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sample,
   input  logic [W-1:0] bits,
   output logic         err_q
);
   logic bad;

   generate
      if (W < 2) begin : g_w_chk
         $error("bec_par_chk: W must cover data and parity");
      end
      if (ODD_PAR) begin : g_odd
         assign bad = ~(^bits);
      end else begin : g_even
         assign bad = ^bits;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= sample & bad;
   end
endmodule

// File: rtl/bec_cfg.sv
module bec_cfg
   import bec_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             addr,
   input  logic [DW-1:0]    wdata,
   input  logic             strap_n,
   input  logic [STS_W-1:0] sts_i,
   output pol_t             pol_o,
   output logic [STS_W-1:0] clr_o,
   output logic [DW-1:0]    rdata
);
   localparam int SW_BITS = POL_W - 1;

   logic [SW_BITS-1:0] sw_q;
   logic               obs_q;
   logic               wdata_unused;

   generate
      if (DW < POL_W) begin : g_dw_chk
         $error("bec_cfg: DW too narrow for policy register");
      end
   endgenerate

   assign wdata_unused = ^wdata[DW-1:SW_BITS];

   always_ff @(posedge clk) begin
      if (!rst_n)                sw_q <= '0;
      else if (we && addr == 1'b0) sw_q <= wdata[SW_BITS-1:0];
   end

   // strap follows the line while reset is held, frozen at release
   always_ff @(posedge clk) begin
      if (!rst_n) obs_q <= ~strap_n;
   end

   assign pol_o = pol_t'({obs_q, sw_q});
   assign clr_o = (we && addr == 1'b1) ? wdata[STS_W-1:0] : '0;

   always_comb begin
      rdata = '0;
      if (addr == 1'b0) rdata[POL_W-1:0] = pol_o;
      else              rdata[STS_W-1:0] = sts_i;
   end
endmodule

// File: rtl/bec_status.sv
module bec_status
   import bec_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [STS_W-1:0] set_i,
   input  logic [STS_W-1:0] clr_i,
   output logic [STS_W-1:0] sts_o
);
   for (genvar i = 0; i < STS_W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)        sts_o[i] <= 1'b0;
         else if (set_i[i]) sts_o[i] <= 1'b1;
         else if (clr_i[i]) sts_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/bec_report.sv
module bec_report
   import bec_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dat_chk,
   input  logic             aerr_drv,
   input  logic             init_drv,
   input  logic             obs_en,
   input  logic             req_err_q,
   input  logic             rsp_err_q,
   input  logic             data_err_in,
   input  logic             aerr_in_n,
   output logic             aerr_out_n,
   output logic             berr_out_n,
   output logic [STS_W-1:0] set_o
);
   logic dat_q;
   logic ext_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dat_q <= 1'b0;
         ext_q <= 1'b0;
      end else begin
         dat_q <= data_err_in & dat_chk;
         ext_q <= ~aerr_in_n & obs_en;
      end
   end

   assign aerr_out_n = ~(req_err_q & aerr_drv);
   // only initiator-side faults reach the bus-error line
   assign berr_out_n = ~((rsp_err_q | dat_q) & init_drv);

   always_comb begin
      set_o         = '0;
      set_o[ST_REQ] = req_err_q;
      set_o[ST_RSP] = rsp_err_q;
      set_o[ST_DAT] = dat_q;
      set_o[ST_EXT] = ext_q;
   end
endmodule

// File: rtl/bus_err_ctrl.sv
module bus_err_ctrl
   import bec_pkg::*;
#(
   parameter int ADDR_LSB  = 3,
   parameter int ADDR_W    = 33,
   parameter int REQ_W     = 5,
   parameter int RS_W      = 3,
   parameter int STRAP_BIT = 8,
   parameter int CFG_DW    = 8,
   parameter bit ODD_PAR   = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic                            cfg_addr,
   input  logic [CFG_DW-1:0]               cfg_wdata,
   output logic [CFG_DW-1:0]               cfg_rdata,
   input  logic [ADDR_LSB+ADDR_W-1:ADDR_LSB] bus_addr_n,
   input  logic                            bus_ads_n,
   input  logic [REQ_W-1:0]                bus_req_n,
   input  logic                            bus_ap_n,
   input  logic [RS_W-1:0]                 bus_rs_n,
   input  logic                            bus_rsp_n,
   input  logic                            data_err_in,
   input  logic                            aerr_in_n,
   output logic                            aerr_out_n,
   output logic                            berr_out_n,
   output logic [3:0]                      sts_o
);
   localparam int ADDR_HI = ADDR_LSB + ADDR_W - 1;
   localparam int REQ_CW  = ADDR_W + 1 + REQ_W + 1;
   localparam int RSP_CW  = RS_W + 1;

   generate
      if (STRAP_BIT < ADDR_LSB || STRAP_BIT > ADDR_HI) begin : g_strap_chk
         $error("bus_err_ctrl: strap bit outside address range");
      end
      if (STS_W != 4) begin : g_sts_chk
         $error("bus_err_ctrl: status width mismatch");
      end
   endgenerate

   pol_t             pol;
   logic [STS_W-1:0] sts;
   logic [STS_W-1:0] sts_set;
   logic [STS_W-1:0] sts_clr;
   logic             req_err_q;
   logic             rsp_err_q;
   logic             rs_valid;

   assign rs_valid = (bus_rs_n != '1);

   bec_cfg #(.DW(CFG_DW)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .addr    (cfg_addr),
      .wdata   (cfg_wdata),
      .strap_n (bus_addr_n[STRAP_BIT]),
      .sts_i   (sts),
      .pol_o   (pol),
      .clr_o   (sts_clr),
      .rdata   (cfg_rdata)
   );

   bec_par_chk #(.W(REQ_CW), .ODD_PAR(ODD_PAR)) u_req_par (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (~bus_ads_n),
      .bits   ({bus_addr_n, bus_ads_n, bus_req_n, bus_ap_n}),
      .err_q  (req_err_q)
   );

   bec_par_chk #(.W(RSP_CW), .ODD_PAR(ODD_PAR)) u_rsp_par (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (rs_valid & pol.rsp_chk),
      .bits   ({bus_rs_n, bus_rsp_n}),
      .err_q  (rsp_err_q)
   );

   bec_report u_rpt (
      .clk         (clk),
      .rst_n       (rst_n),
      .dat_chk     (pol.dat_chk),
      .aerr_drv    (pol.aerr_drv),
      .init_drv    (pol.init_drv),
      .obs_en      (pol.obs_en),
      .req_err_q   (req_err_q),
      .rsp_err_q   (rsp_err_q),
      .data_err_in (data_err_in),
      .aerr_in_n   (aerr_in_n),
      .aerr_out_n  (aerr_out_n),
      .berr_out_n  (berr_out_n),
      .set_o       (sts_set)
   );

   bec_status u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sts_set),
      .clr_i (sts_clr),
      .sts_o (sts)
   );

   assign sts_o = sts;
endmodule

// File: rtl/bus_err_ctrl_chk.sv
module bus_err_ctrl_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_ads_n,
   input logic          rs_valid,
   input logic          data_err_in,
   input logic          aerr_in_n,
   input logic          aerr_out_n,
   input logic          berr_out_n,
   input logic          cfg_we,
   input logic          cfg_addr,
   input logic [DW-1:0] cfg_wdata,
   input logic [5:0]    pol,
   input logic [3:0]    sts
);
   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pol[4:0] == 5'd0 && sts == 4'd0 && aerr_out_n && berr_out_n)); // R1

   AST_AERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !aerr_out_n |-> ($past(!bus_ads_n) && pol[2])); // R3

   AST_BERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      !berr_out_n |-> (pol[3] && ($past(data_err_in && pol[0]) || $past(rs_valid && pol[1])))); // R6

   AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(pol[5])); // R8

   AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[3]) |-> $past(!aerr_in_n && pol[5], 2)); // R9

   AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[2]) |-> $past(cfg_we && cfg_addr && cfg_wdata[2])); // R10
endmodule

bind bus_err_ctrl bus_err_ctrl_chk #(.DW(CFG_DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_ads_n   (bus_ads_n),
   .rs_valid    (rs_valid),
   .data_err_in (data_err_in),
   .aerr_in_n   (aerr_in_n),
   .aerr_out_n  (aerr_out_n),
   .berr_out_n  (berr_out_n),
   .cfg_we      (cfg_we),
   .cfg_addr    (cfg_addr),
   .cfg_wdata   (cfg_wdata),
   .pol         (pol),
   .sts         (sts)
);

// File: tb/bus_err_ctrl_bench.sv
`timescale 1ns/1ps
module bus_err_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic        cfg_addr;
   logic [7:0]  cfg_wdata;
   logic [7:0]  cfg_rdata;
   logic [35:3] bus_addr_n;
   logic        bus_ads_n;
   logic [4:0]  bus_req_n;
   logic        bus_ap_n;
   logic [2:0]  bus_rs_n;
   logic        bus_rsp_n;
   logic        data_err_in;
   logic        aerr_in_n;
   logic        aerr_out_n;
   logic        berr_out_n;
   logic [3:0]  sts_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   bus_err_ctrl u_bus_err_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_addr_n(bus_addr_n),
      .bus_ads_n(bus_ads_n), .bus_req_n(bus_req_n), .bus_ap_n(bus_ap_n),
      .bus_rs_n(bus_rs_n), .bus_rsp_n(bus_rsp_n), .data_err_in(data_err_in),
      .aerr_in_n(aerr_in_n), .aerr_out_n(aerr_out_n), .berr_out_n(berr_out_n),
      .sts_o(sts_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_bus();
      bus_addr_n  = '1;
      bus_ads_n   = 1'b1;
      bus_req_n   = '1;
      bus_ap_n    = 1'b1;
      bus_rs_n    = 3'b111;
      bus_rsp_n   = 1'b1;
      data_err_in = 1'b0;
      aerr_in_n   = 1'b1;
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick();
      cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
      cfg_addr = 1'b0;
   endtask

   // request event; returns aerr level in the two cycles after sampling
   task automatic req_evt(input logic [35:3] a, input logic [4:0] rq, input bit bad,
                          output logic p1, output logic p2);
      bus_addr_n = a;
      bus_req_n  = rq;
      bus_ads_n  = 1'b0;
      bus_ap_n   = (^{a, 1'b0, rq}) ^ bad;
      tick();
      p1 = aerr_out_n;
      idle_bus();
      tick();
      p2 = aerr_out_n;
   endtask

   task automatic rsp_evt(input logic [2:0] rs, input bit bad, output logic p1, output logic p2);
      bus_rs_n  = rs;
      bus_rsp_n = (^rs) ^ bad;
      tick();
      p1 = berr_out_n;
      idle_bus();
      tick();
      p2 = berr_out_n;
   endtask

   task automatic dat_evt(output logic p1, output logic p2);
      data_err_in = 1'b1;
      tick();
      p1 = berr_out_n;
      data_err_in = 1'b0;
      tick();
      p2 = berr_out_n;
   endtask

   task automatic do_reset(input bit strap_on);
      idle_bus();
      cfg_we = 1'b0; cfg_addr = 1'b0; cfg_wdata = '0;
      rst_n = 1'b0;
      bus_addr_n[8] = ~strap_on;
      repeat (3) tick();
      rst_n = 1'b1;
      idle_bus();
      tick();
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset(1'b1);
      rd(1'b0, d);
      chk("R1 policy after reset", d[4:0], 5'd0);
      chk("R8 strap captured active", d[5], 1'b1);
      chk("R11 policy upper bits zero", d[7:6], 2'd0);
      rd(1'b1, d);
      chk("R1 status after reset", d, 8'd0);
      chk("R1 outputs idle", {aerr_out_n, berr_out_n}, 2'b11);
   endtask

   task automatic t_req_parity();
      logic p1, p2;
      logic [7:0] d;
      req_evt(33'h1_2345_6789, 5'b10110, 1'b0, p1, p2);
      rd(1'b1, d);
      chk("R2 good request parity no flag", d[0], 1'b0);
      req_evt(33'h0_F0F0_0F0F, 5'b00011, 1'b1, p1, p2);
      chk("R3 aerr silent when drive off", {p1, p2}, 2'b11);
      rd(1'b1, d);
      chk("R2 bad request parity flagged", d[0], 1'b1);
      chk("R11 status port matches read", sts_o, d[3:0]);
      wr(1'b1, 8'h01);
      wr(1'b0, 8'h04);
      req_evt(33'h1_FFFF_FFFE, 5'b11111, 1'b1, p1, p2);
      chk("R3 aerr single pulse when drive on", {p1, p2}, 2'b01);
      req_evt(33'h0_0000_0001, 5'b01010, 1'b0, p1, p2);
      chk("R3 aerr quiet on good parity", {p1, p2}, 2'b11);
      wr(1'b1, 8'h0F);
   endtask

   task automatic t_rsp_parity();
      logic p1, p2;
      logic [7:0] d;
      wr(1'b0, 8'h08);
      rsp_evt(3'b010, 1'b1, p1, p2);
      rd(1'b1, d);
      chk("R4 response check off ignores fault", d[1], 1'b0);
      chk("R4 no berr with response check off", {p1, p2}, 2'b11);
      wr(1'b0, 8'h02);
      rsp_evt(3'b100, 1'b1, p1, p2);
      rd(1'b1, d);
      chk("R4 response fault flagged", d[1], 1'b1);
      chk("R6 berr silent with initiator drive off", {p1, p2}, 2'b11);
      wr(1'b1, 8'h02);
      wr(1'b0, 8'h0A);
      rsp_evt(3'b001, 1'b1, p1, p2);
      chk("R6 berr pulse on response fault", {p1, p2}, 2'b01);
      rsp_evt(3'b011, 1'b0, p1, p2);
      chk("R4 good response no berr", {p1, p2}, 2'b11);
      wr(1'b1, 8'h0F);
   endtask

   task automatic t_data();
      logic p1, p2;
      logic [7:0] d;
      wr(1'b0, 8'h08);
      dat_evt(p1, p2);
      rd(1'b1, d);
      chk("R5 data check off ignores input", {d[2], p1, p2}, 3'b011);
      wr(1'b0, 8'h09);
      dat_evt(p1, p2);
      rd(1'b1, d);
      chk("R5 data fault flagged", d[2], 1'b1);
      chk("R6 berr pulse on data fault", {p1, p2}, 2'b01);
      wr(1'b1, 8'h0F);
   endtask

   task automatic t_target();
      logic p1, p2;
      logic [7:0] d;
      wr(1'b0, 8'h13);
      rd(1'b0, d);
      chk("R7 target drive bit reads back", d[4], 1'b1);
      dat_evt(p1, p2);
      chk("R7 target bit never drives berr (data)", {p1, p2}, 2'b11);
      rsp_evt(3'b110, 1'b1, p1, p2);
      chk("R7 target bit never drives berr (response)", {p1, p2}, 2'b11);
      wr(1'b1, 8'h0F);
   endtask

   task automatic t_strap_ro();
      logic [7:0] d;
      wr(1'b0, 8'h00);
      rd(1'b0, d);
      chk("R8 write of zero keeps strap bit", d[5:0], 6'h20);
   endtask

   task automatic t_observe_on();
      logic [7:0] d;
      aerr_in_n = 1'b0;
      tick();
      aerr_in_n = 1'b1;
      rd(1'b1, d);
      chk("R9 not yet visible one edge later", d[3], 1'b0);
      tick();
      rd(1'b1, d);
      chk("R9 external error recorded", d[3], 1'b1);
      wr(1'b1, 8'h08);
   endtask

   task automatic t_clear_race();
      logic [7:0] d;
      wr(1'b0, 8'h01);
      data_err_in = 1'b1;
      tick();
      data_err_in = 1'b0;
      wr(1'b1, 8'h04);
      rd(1'b1, d);
      chk("R10 set wins over clear in same edge", d[2], 1'b1);
      wr(1'b1, 8'h00);
      rd(1'b1, d);
      chk("R10 writing zero leaves status", d[2], 1'b1);
      wr(1'b1, 8'h04);
      rd(1'b1, d);
      chk("R10 write one clears status", d[2], 1'b0);
   endtask

   task automatic t_observe_off();
      logic [7:0] d;
      do_reset(1'b0);
      rd(1'b0, d);
      chk("R8 strap captured inactive", d[5], 1'b0);
      aerr_in_n = 1'b0;
      repeat (3) tick();
      aerr_in_n = 1'b1;
      tick();
      rd(1'b1, d);
      chk("R9 receiver off ignores input", d, 8'd0);
      wr(1'b0, 8'h3F);
      rd(1'b0, d);
      chk("R8 software cannot set strap bit", d[5], 1'b0);
   endtask

   initial begin
      rst_n = 1'b0;
      t_reset();
      t_req_parity();
      t_rsp_parity();
      t_data();
      t_target();
      t_strap_ro();
      t_observe_on();
      t_clear_race();
      t_observe_off();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule